// File: doc/BRIEF.md
# Frame-Paced Two-Bank Digital Channel Sequencer

This block services sixteen general-purpose digital channels once per audio frame. Each frame has one 32-bit control word in a frame buffer in local memory. In that word the low half gives each channel's direction and the high half gives each channel's level. When a converter transaction with the right count arrives and the digital function is enabled, the block does four things in order:

- It reads the word for the current frame.
- It spreads the channels over two GPIO banks through a fixed, non-contiguous pin map.
- It samples the input pins.
- It writes the updated word back in place and moves to the next frame slot.

For every pass, each bank receives three words: an output-enable word built by read-modify-write from the bank's current value, a set mask and a clear mask. A `bank_wr` strobe marks the cycle in which these words are valid. The pointer restarts at the buffer base at the start of each buffer period, and sits 0x400 bytes higher when the second buffer is active.

Top module: `fgpio_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `bank_wr`, `mem_rd_en`, `mem_wr_en` and all six bank output words are 0, and the pointer is at the base address.
- R2: A pass starts only from idle, on `xact_go` with `dig_en` high and `xact_cnt_lo` equal to 2'b00. Any other combination causes no memory access.
- R3: Word bit c (c < 16) is the direction of channel c, where 1 means input and 0 means output. In the bank output-enable word, an input channel's pin bit is 1 and an output channel's pin bit is 0. Every unmapped bank bit keeps the value read from that bank's `*_oe_rd` input.
- R4: For an output channel, level 1 sets its pin bit in the set mask and level 0 sets it in the clear mask. Both masks start from zero on every pass, so nothing carries over between frames.
- R5: For an input channel, the sampled bank data-in bit of its pin is written to word bit c+16. The levels of output channels and the whole direction half are written back unchanged.
- R6: The pins are fixed. Bank A is encoded 0 and bank B is encoded 1 in the map. Channels 0, 1, 2, 3 and 11 go to bank B bits 2, 3, 5, 4 and 1. Channels 4, 5, 6, 7, 8, 9 and 10 go to bank A bits 13, 12, 28, 18, 15, 14 and 19. Channel 12 goes to bank B bit 22.
- R7: Channels 13, 14 and 15 have no pin. Their direction and level bits are written back untouched, and they place no bit in any bank word.
- R8: The updated word is written to the address it was read from, two cycles after the read. The next pass uses that address plus 4.
- R9: A `frame_restart` pulse loads the pointer with the base address (0x11000) when `buf_sel` is 0, or with base + 0x400 when it is 1. A restart takes priority over a pointer advance in the same cycle.
- R10: After 256 passes since the last restart, further triggers are ignored until the next restart.
- R11: `busy` is high from the read cycle through the write cycle. `done` is high for exactly the one write cycle, together with `bank_wr`. Triggers that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dig_en | input | 1 | Digital channel function enable |
| xact_go | input | 1 | One-cycle pulse per converter transaction |
| xact_cnt_lo | input | 2 | Two low bits of the transaction count |
| frame_restart | input | 1 | Start of a buffer period, reloads the pointer |
| buf_sel | input | 1 | 1 selects the second frame buffer |
| mem_rd_en | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the frame word |
| mem_wdata | output | 32 | Updated frame word |
| mem_rdata | input | 32 | Frame word returned by memory |
| bka_oe_rd | input | 32 | Current output-enable value of bank A |
| bkb_oe_rd | input | 32 | Current output-enable value of bank B |
| bka_din | input | 32 | Pin levels of bank A |
| bkb_din | input | 32 | Pin levels of bank B |
| bka_oe | output | 32 | New output-enable word for bank A |
| bka_set | output | 32 | Set mask for bank A |
| bka_clr | output | 32 | Clear mask for bank A |
| bkb_oe | output | 32 | New output-enable word for bank B |
| bkb_set | output | 32 | Set mask for bank B |
| bkb_clr | output | 32 | Clear mask for bank B |
| bank_wr | output | 1 | Bank words valid; apply them this cycle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Write-back cycle of a pass |

## Verification
The assertions check the following on every cycle:
- the start gating;
- the write-back landing on the address that was read, two cycles later;
- the direction half surviving the pass;
- no pin appearing in both the set and clear masks;
- every driven pin being marked as an output;
- the single-cycle `done` that coincides with the write.

The pin table needs the bench's directed scenarios, which walk a lone output across every channel and compare whole bank words. The same holds for sampled levels landing in the right word bits, for unmapped channels staying untouched, and for the second-buffer offset. The 256-frame limit and the rejection of triggers during a pass also rely on the scenarios, because they are only visible as counts of memory accesses and as pointer positions.

// File: rtl/fgpio_pkg.sv
// fgpio_pkg: shared constants, state type and pin-map helpers for the
// frame-paced digital channel sequencer.
// Assumes 16 channels packed into a 32-bit word and two 32-bit banks.
package fgpio_pkg;

    localparam int CH_N    = 16;
    localparam int WORD_W  = 2 * CH_N;
    localparam int BANK_W  = 32;
    localparam int SEL_W   = $clog2(BANK_W);
    localparam int ENTRY_W = SEL_W + 2;   // {used, bank, pin bit}

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_PROC,
        ST_WRITE
    } seq_state_t;

    // Build one map entry: used flag, bank (0 = A, 1 = B), pin bit.
    function automatic logic [ENTRY_W-1:0] pin(input bit used, input bit bank_b, input int b);
        logic [SEL_W-1:0] sel;
        sel = b[SEL_W-1:0];
        return {used, bank_b, sel};
    endfunction

    // Default channel-to-pin table.
    function automatic logic [CH_N*ENTRY_W-1:0] default_map();
        logic [CH_N*ENTRY_W-1:0] m;
        m = '0;
        m[ 0*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b1,  2);
        m[ 1*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b1,  3);
        m[ 2*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b1,  5);
        m[ 3*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b1,  4);
        m[ 4*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b0, 13);
        m[ 5*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b0, 12);
        m[ 6*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b0, 28);
        m[ 7*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b0, 18);
        m[ 8*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b0, 15);
        m[ 9*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b0, 14);
        m[10*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b0, 19);
        m[11*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b1,  1);
        m[12*ENTRY_W +: ENTRY_W] = pin(1'b1, 1'b1, 22);
        return m;
    endfunction

    // Mask of every bank bit owned by some channel, bank B in the upper half.
    function automatic logic [2*BANK_W-1:0] map_mask(input logic [CH_N*ENTRY_W-1:0] m);
        logic [2*BANK_W-1:0] r;
        logic [ENTRY_W-1:0]  e;
        r = '0;
        for (int i = 0; i < CH_N; i++) begin
            e = m[i*ENTRY_W +: ENTRY_W];
            if (e[ENTRY_W-1])
                r[int'(e[SEL_W]) * BANK_W + int'(e[SEL_W-1:0])] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fgpio_lane.sv
// fgpio_lane: per-channel decision for one mapped channel.
// Takes the channel's direction and level bits plus the sampled pin level.
// Produces the output-enable bit (1 = input), the set and clear requests,
// and the level to write back. Assumes the caller has selected the pin.
module fgpio_lane (
    input  logic dir_i,
    input  logic lvl_i,
    input  logic samp_i,
    output logic oe_o,
    output logic set_o,
    output logic clr_o,
    output logic lvl_o
);

    // Pure combinational channel decision.
    always_comb begin
        oe_o  = dir_i;
        set_o = !dir_i && lvl_i;
        clr_o = !dir_i && !lvl_i;
        lvl_o = dir_i ? samp_i : lvl_i;
    end

endmodule

// File: rtl/fgpio_ptr.sv
// fgpio_ptr: frame pointer and per-buffer frame counter.
// The pointer reloads on restart (the second buffer adds BUF1_OFS) and
// otherwise steps by one 4-byte word per completed pass. full_o rises
// once FRAMES_MAX passes have been made since the last restart.
module fgpio_ptr #(
    parameter int                ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 20'h11000,
    parameter logic [ADDR_W-1:0] BUF1_OFS   = 20'h00400,
    parameter int                FRAMES_MAX = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              buf_sel_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              full_o
);

    localparam int CNT_W = $clog2(FRAMES_MAX + 1);

    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    // Pointer and count update; restart wins over a step in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= BASE_ADDR;
            cnt_q <= '0;
        end else if (restart_i) begin
            ptr_q <= buf_sel_i ? (BASE_ADDR + BUF1_OFS) : BASE_ADDR;
            cnt_q <= '0;
        end else if (step_i) begin
            ptr_q <= ptr_q + ADDR_W'(4);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ptr_o  = ptr_q;
    assign full_o = (cnt_q == CNT_W'(FRAMES_MAX));

endmodule

// File: rtl/fgpio_ctrl.sv
// fgpio_ctrl: four-state pass sequencer (idle, read, process, write).
// Assumes memory data returns one cycle after the read strobe.
// start_i is honoured only in idle.
module fgpio_ctrl
    import fgpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic rd_o,
    output logic cap_o,
    output logic wr_o,
    output logic busy_o
);

    seq_state_t st_q, st_n;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Next-state decision.
    always_comb begin
        st_n = st_q;
        case (st_q)
            ST_IDLE:  if (start_i) st_n = ST_READ;
            ST_READ:  st_n = ST_PROC;
            ST_PROC:  st_n = ST_WRITE;
            ST_WRITE: st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // State-decoded strobes.
    always_comb begin
        rd_o   = (st_q == ST_READ);
        cap_o  = (st_q == ST_PROC);
        wr_o   = (st_q == ST_WRITE);
        busy_o = (st_q != ST_IDLE);
    end

endmodule

// File: rtl/fgpio_seq.sv
// fgpio_seq: frame-paced two-bank digital channel sequencer (top).
// Per accepted trigger it reads one frame word, derives the bank
// output-enable, set and clear words, merges the sampled inputs into the
// word, and writes the word back in place.
// Assumes a 1-cycle read latency and bank inputs stable in the process cycle.
module fgpio_seq
    import fgpio_pkg::*;
#(
    parameter int                         ADDR_W     = 20,
    parameter logic [ADDR_W-1:0]          BASE_ADDR  = 20'h11000,
    parameter logic [ADDR_W-1:0]          BUF1_OFS   = 20'h00400,
    parameter int                         FRAMES_MAX = 256,
    parameter logic [CH_N*ENTRY_W-1:0]    PIN_MAP    = fgpio_pkg::default_map()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dig_en,
    input  logic              xact_go,
    input  logic [1:0]        xact_cnt_lo,
    input  logic              frame_restart,
    input  logic              buf_sel,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [BANK_W-1:0] bka_oe_rd,
    input  logic [BANK_W-1:0] bkb_oe_rd,
    input  logic [BANK_W-1:0] bka_din,
    input  logic [BANK_W-1:0] bkb_din,
    output logic [BANK_W-1:0] bka_oe,
    output logic [BANK_W-1:0] bka_set,
    output logic [BANK_W-1:0] bka_clr,
    output logic [BANK_W-1:0] bkb_oe,
    output logic [BANK_W-1:0] bkb_set,
    output logic [BANK_W-1:0] bkb_clr,
    output logic              bank_wr,
    output logic              busy,
    output logic              done
);

    localparam int                  BB_W     = 2 * BANK_W;
    localparam logic [BB_W-1:0]     MAP_MASK = fgpio_pkg::map_mask(PIN_MAP);

    logic              rd, cap, wr, start, ptr_full;
    logic [ADDR_W-1:0] ptr, addr_q;
    logic [BB_W-1:0]   din_all, oe_rd_all;
    logic [BB_W-1:0]   ch_oe  [CH_N];
    logic [BB_W-1:0]   ch_set [CH_N];
    logic [BB_W-1:0]   ch_clr [CH_N];
    logic [CH_N-1:0]   lvl_new;
    logic [BB_W-1:0]   acc_oe, acc_set, acc_clr, oe_next;
    logic [WORD_W-1:0] word_q;
    logic [BB_W-1:0]   oe_q, set_q, clr_q;

    assign start     = xact_go && dig_en && (xact_cnt_lo == 2'b00) && !ptr_full;
    assign din_all   = {bkb_din, bka_din};
    assign oe_rd_all = {bkb_oe_rd, bka_oe_rd};

    fgpio_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .rd_o    (rd),
        .cap_o   (cap),
        .wr_o    (wr),
        .busy_o  (busy)
    );

    fgpio_ptr #(
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .BUF1_OFS   (BUF1_OFS),
        .FRAMES_MAX (FRAMES_MAX)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (frame_restart),
        .buf_sel_i (buf_sel),
        .step_i    (wr),
        .ptr_o     (ptr),
        .full_o    (ptr_full)
    );

    // One lane per mapped channel; unmapped channels pass their bits through.
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        localparam logic [ENTRY_W-1:0] ENT = PIN_MAP[ch*ENTRY_W +: ENTRY_W];
        if (ENT[ENTRY_W-1]) begin : g_pin
            localparam int            POS = int'(ENT[SEL_W]) * BANK_W + int'(ENT[SEL_W-1:0]);
            localparam logic [BB_W-1:0] HIT = BB_W'(1) << POS;
            logic en_b, set_b, clr_b;
            fgpio_lane u_lane (
                .dir_i  (mem_rdata[ch]),
                .lvl_i  (mem_rdata[CH_N+ch]),
                .samp_i (din_all[POS]),
                .oe_o   (en_b),
                .set_o  (set_b),
                .clr_o  (clr_b),
                .lvl_o  (lvl_new[ch])
            );
            assign ch_oe[ch]  = en_b  ? HIT : '0;
            assign ch_set[ch] = set_b ? HIT : '0;
            assign ch_clr[ch] = clr_b ? HIT : '0;
        end else begin : g_nopin
            assign ch_oe[ch]    = '0;
            assign ch_set[ch]   = '0;
            assign ch_clr[ch]   = '0;
            assign lvl_new[ch]  = mem_rdata[CH_N+ch];
        end
    end

    // Merge lane contributions; set and clear masks start from zero every pass.
    always_comb begin
        acc_oe  = '0;
        acc_set = '0;
        acc_clr = '0;
        for (int i = 0; i < CH_N; i++) begin
            acc_oe  = acc_oe  | ch_oe[i];
            acc_set = acc_set | ch_set[i];
            acc_clr = acc_clr | ch_clr[i];
        end
        oe_next = (oe_rd_all & ~MAP_MASK) | acc_oe;
    end

    // Capture the access address at read and the pass results at process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            word_q <= '0;
            oe_q   <= '0;
            set_q  <= '0;
            clr_q  <= '0;
        end else begin
            if (rd) addr_q <= ptr;
            if (cap) begin
                word_q <= {lvl_new, mem_rdata[CH_N-1:0]};
                oe_q   <= oe_next;
                set_q  <= acc_set;
                clr_q  <= acc_clr;
            end
        end
    end

    assign mem_rd_en = rd;
    assign mem_wr_en = wr;
    assign mem_addr  = rd ? ptr : addr_q;
    assign mem_wdata = word_q;
    assign bka_oe    = oe_q[BANK_W-1:0];
    assign bkb_oe    = oe_q[BB_W-1:BANK_W];
    assign bka_set   = set_q[BANK_W-1:0];
    assign bkb_set   = set_q[BB_W-1:BANK_W];
    assign bka_clr   = clr_q[BANK_W-1:0];
    assign bkb_clr   = clr_q[BB_W-1:BANK_W];
    assign bank_wr   = wr;
    assign done      = wr;

endmodule

// File: rtl/fgpio_seq_chk.sv
// fgpio_seq_chk: cycle-level properties of fgpio_seq, attached by bind.
// Assumes it sees the top's ports only.
module fgpio_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dig_en,
    input logic              xact_go,
    input logic [1:0]        xact_cnt_lo,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [31:0]       mem_rdata,
    input logic [31:0]       bka_oe,
    input logic [31:0]       bka_set,
    input logic [31:0]       bka_clr,
    input logic [31:0]       bkb_oe,
    input logic [31:0]       bkb_set,
    input logic [31:0]       bkb_clr,
    input logic              bank_wr,
    input logic              busy,
    input logic              done
);

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(xact_go && dig_en && (xact_cnt_lo == 2'b00))); // R2

    AST_DRIVEN_IS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> ((((bka_set | bka_clr) & bka_oe) | ((bkb_set | bkb_clr) & bkb_oe)) == 32'h0)); // R3

    AST_SET_CLR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> (((bka_set & bka_clr) | (bkb_set & bkb_clr)) == 32'h0)); // R4

    AST_DIR_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wdata[15:0] == $past(mem_rdata[15:0]))); // R5

    AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 (mem_wr_en && (mem_addr == $past(mem_addr, 2)))); // R8

    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_wr_en && bank_wr && busy)); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R11

endmodule

bind fgpio_seq fgpio_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dig_en      (dig_en),
    .xact_go     (xact_go),
    .xact_cnt_lo (xact_cnt_lo),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .bka_oe      (bka_oe),
    .bka_set     (bka_set),
    .bka_clr     (bka_clr),
    .bkb_oe      (bkb_oe),
    .bkb_set     (bkb_set),
    .bkb_clr     (bkb_clr),
    .bank_wr     (bank_wr),
    .busy        (busy),
    .done        (done)
);

// File: tb/sim_fgpio_seq.sv
`timescale 1ns/1ps
// sim_fgpio_seq: directed bench, one task per scenario.
module sim_fgpio_seq;

    localparam int          ADDR_W = 20;
    localparam logic [19:0] BASE   = 20'h11000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dig_en = 1'b0, xact_go = 1'b0, frame_restart = 1'b0, buf_sel = 1'b0;
    logic [1:0]  xact_cnt_lo = 2'b00;
    logic        mem_rd_en, mem_wr_en, bank_wr, busy, done;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic [31:0] bka_oe_rd = '0, bkb_oe_rd = '0, bka_din = '0, bkb_din = '0;
    logic [31:0] bka_oe, bka_set, bka_clr, bkb_oe, bkb_set, bkb_clr;

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [19:0] last_wr_addr = '0;
    logic [19:0] nxt = BASE;
    logic [31:0] mem [512];
    logic        poke_en = 1'b0;
    int          poke_idx = 0;
    logic [31:0] poke_val = '0;
    logic [63:0] e_oe, e_set, e_clr;
    logic [31:0] e_word;

    always #4 clk = ~clk;

    fgpio_seq u0 (
        .clk(clk), .rst_n(rst_n), .dig_en(dig_en), .xact_go(xact_go),
        .xact_cnt_lo(xact_cnt_lo), .frame_restart(frame_restart), .buf_sel(buf_sel),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .bka_oe_rd(bka_oe_rd), .bkb_oe_rd(bkb_oe_rd), .bka_din(bka_din), .bkb_din(bkb_din),
        .bka_oe(bka_oe), .bka_set(bka_set), .bka_clr(bka_clr),
        .bkb_oe(bkb_oe), .bkb_set(bkb_set), .bkb_clr(bkb_clr),
        .bank_wr(bank_wr), .busy(busy), .done(done)
    );

    // Memory model: one-cycle read, in-place write, bench preload port.
    always @(posedge clk) begin
        if (poke_en) mem[poke_idx] <= poke_val;
        else if (mem_wr_en) begin
            mem[int'((mem_addr - BASE) >> 2)] <= mem_wdata;
            wr_cnt       <= wr_cnt + 1;
            last_wr_addr <= mem_addr;
        end
        if (mem_rd_en) begin
            mem_rdata <= mem[int'((mem_addr - BASE) >> 2)];
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Pin table from the requirements: bank*32 + bit, or -1 when unmapped.
    function automatic int pinpos(input int ch);
        case (ch)
            0: return 32 + 2;   1: return 32 + 3;   2: return 32 + 5;   3: return 32 + 4;
            4: return 13;       5: return 12;       6: return 28;       7: return 18;
            8: return 15;       9: return 14;       10: return 19;      11: return 32 + 1;
            12: return 32 + 22;
            default: return -1;
        endcase
    endfunction

    // Expected bank words and written word for one pass.
    task automatic model(input logic [31:0] w);
        e_oe   = {bkb_oe_rd, bka_oe_rd};
        e_set  = '0;
        e_clr  = '0;
        e_word = w;
        for (int ch = 0; ch < 16; ch++) begin
            int p;
            p = pinpos(ch);
            if (p >= 0) begin
                if (w[ch]) begin
                    e_oe[p] = 1'b1;
                    e_word[16+ch] = (p >= 32) ? bkb_din[p-32] : bka_din[p];
                end else begin
                    e_oe[p] = 1'b0;
                    if (w[16+ch]) e_set[p] = 1'b1;
                    else          e_clr[p] = 1'b1;
                end
            end
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = idx; poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic pulse_go(input logic en, input logic [1:0] cnt);
        @(negedge clk);
        dig_en = en; xact_cnt_lo = cnt; xact_go = 1'b1;
        @(negedge clk);
        xact_go = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 8 && !done; i++) @(negedge clk);
    endtask

    // One full pass with checks on the bank words, the address and the stored word.
    task automatic do_frame(input logic [31:0] w, input string req);
        int idx;
        idx = int'((nxt - BASE) >> 2);
        poke(idx, w);
        model(w);
        pulse_go(1'b1, 2'b00);
        wait_done();
        chk(done && bank_wr && busy, {req, " R11 done/busy"}, {61'b0, done, bank_wr, busy}, 64'h7);
        chk(mem_addr == nxt, {req, " R8 addr"}, 64'(mem_addr), 64'(nxt));
        chk(mem_wdata == e_word, {req, " R5 word"}, 64'(mem_wdata), 64'(e_word));
        chk({bkb_oe, bka_oe} == e_oe, {req, " R3 oe"}, {bkb_oe, bka_oe}, e_oe);
        chk({bkb_set, bka_set} == e_set, {req, " R4 set"}, {bkb_set, bka_set}, e_set);
        chk({bkb_clr, bka_clr} == e_clr, {req, " R4 clr"}, {bkb_clr, bka_clr}, e_clr);
        @(negedge clk);
        chk(!busy && !done, {req, " R11 idle after"}, {62'b0, busy, done}, 64'h0);
        chk(mem[idx] == e_word, {req, " R8 stored"}, 64'(mem[idx]), 64'(e_word));
        nxt = nxt + 20'd4;
    endtask

    task automatic restart(input logic sel);
        @(negedge clk);
        frame_restart = 1'b1; buf_sel = sel;
        @(negedge clk);
        frame_restart = 1'b0;
        nxt = sel ? BASE + 20'h400 : BASE;
    endtask

    task automatic t_reset();
        chk(!busy && !done && !bank_wr && !mem_rd_en && !mem_wr_en, "R1 strobes",
            {59'b0, busy, done, bank_wr, mem_rd_en, mem_wr_en}, 64'h0);
        chk({bka_oe, bka_set, bka_clr} == '0 && {bkb_oe, bkb_set, bkb_clr} == '0, "R1 bank words",
            {bka_oe, bkb_oe}, 64'h0);
    endtask

    task automatic t_gating();
        int r0;
        r0 = rd_cnt;
        pulse_go(1'b0, 2'b00);
        pulse_go(1'b1, 2'b01);
        pulse_go(1'b1, 2'b10);
        pulse_go(1'b1, 2'b11);
        repeat (4) @(negedge clk);
        chk(rd_cnt == r0 && !busy, "R2 gated triggers", 64'(rd_cnt - r0), 64'h0);
    endtask

    task automatic t_outputs();
        bka_oe_rd = 32'hFFFF_FFFF; bkb_oe_rd = 32'hFFFF_FFFF;
        bka_din = '0; bkb_din = '0;
        do_frame(32'hA5C3_0000, "R3 R4 all outputs");
        do_frame(32'h5A3C_0000, "R4 complement levels");
    endtask

    task automatic t_inputs();
        bka_oe_rd = 32'h0000_0000; bkb_oe_rd = 32'h1234_5678;
        bka_din = 32'h1005_A000; bkb_din = 32'h0040_0024;
        do_frame(32'h0000_FFFF, "R5 all inputs");
        chk({bkb_set, bka_set} == '0, "R4 no carry-over of set", {bkb_set, bka_set}, 64'h0);
        bka_din = ~bka_din; bkb_din = ~bkb_din;
        do_frame(32'hFFFF_0F0F, "R5 mixed inputs");
    endtask

    task automatic t_walk();
        bka_oe_rd = 32'hFFFF_FFFF; bkb_oe_rd = 32'hFFFF_FFFF;
        bka_din = '0; bkb_din = '0;
        for (int ch = 0; ch < 16; ch++) begin
            logic [31:0] w;
            w = {16'(1 << ch), ~16'(1 << ch)};
            do_frame(w, (ch >= 13) ? "R7 walk unmapped" : "R6 walk");
        end
    endtask

    task automatic t_unused();
        logic [31:0] w;
        bka_din = 32'hFFFF_FFFF; bkb_din = 32'hFFFF_FFFF;
        w = 32'h4000_6000;
        do_frame(w, "R7 unmapped bits");
        chk(mem_wdata[31:29] == w[31:29] && mem_wdata[15:13] == w[15:13], "R7 untouched bits",
            64'({mem_wdata[31:29], mem_wdata[15:13]}), 64'({w[31:29], w[15:13]}));
    endtask

    task automatic t_buffer();
        restart(1'b1);
        do_frame(32'h0001_0000, "R9 second buffer");
        do_frame(32'h0002_0000, "R8 step in second buffer");
        restart(1'b0);
        do_frame(32'h0004_0000, "R9 first buffer");
    endtask

    task automatic t_busy_ignore();
        int w0;
        poke(int'((nxt - BASE) >> 2), 32'h0);
        w0 = wr_cnt;
        pulse_go(1'b1, 2'b00);
        pulse_go(1'b1, 2'b00);
        repeat (6) @(negedge clk);
        chk(wr_cnt == w0 + 1, "R11 one pass for two triggers", 64'(wr_cnt - w0), 64'h1);
        nxt = nxt + 20'd4;
        do_frame(32'h0008_0000, "R11 pointer stepped once");
    endtask

    task automatic t_limit();
        int r0;
        restart(1'b0);
        for (int f = 0; f < 256; f++) begin
            pulse_go(1'b1, 2'b00);
            wait_done();
            @(negedge clk);
        end
        chk(last_wr_addr == BASE + 20'(255 * 4), "R10 last slot", 64'(last_wr_addr), 64'(BASE + 20'(255 * 4)));
        r0 = rd_cnt;
        pulse_go(1'b1, 2'b00);
        repeat (4) @(negedge clk);
        chk(rd_cnt == r0 && !busy, "R10 trigger past limit", 64'(rd_cnt - r0), 64'h0);
        restart(1'b0);
        do_frame(32'h0010_0000, "R10 resume after restart");
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gating();
        t_outputs();
        t_inputs();
        t_walk();
        t_unused();
        t_buffer();
        t_busy_ignore();
        t_limit();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule